// File: doc/BRIEF.md
# Sleep Mode Controller

This block decides when a microcontroller core enters a low-power state, which clock domains stay alive while it sleeps, which interrupt sources may end the sleep, and how long the core stays halted on the way back. Software arms a sleep-enable bit and picks a 3-bit mode. A one-cycle sleep-instruction strobe then requests entry. A request with a reserved mode code, or a request for standby while no crystal clock is selected, is dropped and the core keeps running.

While asleep, the block drives one clock enable each for the CPU, flash, I/O, ADC and asynchronous-timer domains, plus a run enable for the main oscillator. Wake requests pass through a two-flop synchronizer and are then masked by a per-mode table. A legal wake goes through an oscillator start-up wait that depends on the mode. A fixed halt of four cycles follows, during which every clock runs but the CPU stays halted. An asynchronous reset at any time returns the block straight to the running state.

Top module: `slpc_top`

## Requirements
- R1: Sleep is entered only on a cycle where the block is running, `sleep_strobe` is 1 and `sleep_en` is 1. The cycle after that clock edge shows `cpu_halt`=1. Without the strobe, or with `sleep_en`=0, the block stays running.
- R2: Mode codes are 000 idle, 001 ADC quiet, 010 power-down, 011 power-save and 110 standby. A request with code 100, 101 or 111 is ignored and `cpu_halt` stays 0.
- R3: In idle, the CPU and flash enables are 0 while I/O, ADC and the oscillator stay 1. ADC-quiet mode is the same except that the I/O enable is also 0. In both modes the async enable follows `async_tmr`.
- R4: In power-down, every domain enable and `osc_run_en` are 0. In power-save, only the async enable may be 1, and it follows `async_tmr`.
- R5: Standby is entered only when `xtal_sel`=1, otherwise the request is ignored. In standby every domain enable is 0 and `osc_run_en` is 1.
- R6: `wake_req` bits are: 0 external level interrupt, 1 two-wire address match, 2 timer-2 event, 3 memory-ready, 4 ADC done, 5 any other I/O interrupt. Idle accepts all six. ADC-quiet accepts bits 0 to 4. Power-down and standby accept bits 0 and 1 only. Power-save accepts bits 0 and 1, and also bit 2 under the conditions of R7. A request that is not accepted leaves the core halted.
- R7: Every interrupt wake needs `gie`=1. Bit 2 also needs `tmr2_ie`=1. In power-save, bit 2 also needs `async_tmr`=1.
- R8: When entry is into idle or ADC-quiet mode with `adc_on`=1, `adc_start` is 1 for exactly the first sleeping cycle. For every other entry, or with `adc_on`=0, it stays 0.
- R9: After an accepted wake request is first presented, `cpu_halt` falls exactly 7+S clock edges later. S is 0 for idle and ADC-quiet, `STARTUP_CYC` for power-down and power-save, and `STBY_CYC` (6) for standby. During the start-up wait `osc_run_en` is 1 and the domains stay gated. `cpu_halt` stays 1 for the last 4 cycles before it falls.
- R10: Asserting `rst_n` low during sleep immediately clears `cpu_halt` and turns every clock enable on, except the async enable, which follows `async_tmr`.
- R11: While running, the CPU, flash, I/O, ADC and oscillator enables are 1, the async enable equals `async_tmr`, and `cpu_halt` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on control clock |
| rst_n | input | 1 | Asynchronous active-low reset, covering all reset sources |
| sleep_en | input | 1 | Sleep-enable bit |
| mode_sel | input | 3 | Requested sleep mode code |
| sleep_strobe | input | 1 | One-cycle sleep-instruction strobe |
| xtal_sel | input | 1 | Crystal or resonator is the selected main clock |
| async_tmr | input | 1 | Timer 2 runs from its own asynchronous clock |
| adc_on | input | 1 | ADC is enabled |
| gie | input | 1 | Global interrupt enable |
| tmr2_ie | input | 1 | Timer-2 interrupt enable |
| wake_req | input | 6 | Unsynchronized wake request per source (bits as in R6) |
| clk_cpu_en | output | 1 | CPU clock enable |
| clk_flash_en | output | 1 | Flash clock enable |
| clk_io_en | output | 1 | I/O clock enable |
| clk_adc_en | output | 1 | ADC clock enable |
| clk_asy_en | output | 1 | Asynchronous-timer clock enable |
| osc_run_en | output | 1 | Main oscillator run enable |
| cpu_halt | output | 1 | CPU halted (sleep, start-up or post-wake halt) |
| adc_start | output | 1 | One-cycle ADC conversion start on entry |

## Verification
The checks assume that `sleep_strobe` is a single-cycle pulse. They also assume that the mode and control inputs are steady while a request is evaluated. The stimulus changes inputs only on the falling clock edge, raises the strobe for exactly one cycle, and keeps `mode_sel`, `xtal_sel` and the enables fixed during each sleep episode. Wake requests are held high until the halt ends. This matches the level nature of the real sources and lets the synchronizer latency be counted exactly.

// File: rtl/slpc_pkg.sv
package slpc_pkg;

  localparam logic [2:0] MODE_IDLE  = 3'b000;
  localparam logic [2:0] MODE_ADCQ  = 3'b001;
  localparam logic [2:0] MODE_PDOWN = 3'b010;
  localparam logic [2:0] MODE_PSAVE = 3'b011;
  localparam logic [2:0] MODE_STBY  = 3'b110;

  localparam int NWAKE  = 6;
  localparam int WK_LVL = 0;
  localparam int WK_TWI = 1;
  localparam int WK_TM2 = 2;
  localparam int WK_NVM = 3;
  localparam int WK_ADC = 4;
  localparam int WK_IO  = 5;

  typedef enum logic [1:0] {ST_RUN, ST_SLEEP, ST_START, ST_HALT} slp_state_e;

  typedef struct packed {
    logic cpu;
    logic flash;
    logic io;
    logic adc;
    logic asy;
    logic osc;
  } dom_en_t;

  function automatic logic mode_legal(input logic [2:0] m, input logic xtal);
    case (m)
      MODE_IDLE, MODE_ADCQ, MODE_PDOWN, MODE_PSAVE: mode_legal = 1'b1;
      MODE_STBY:                                    mode_legal = xtal;
      default:                                      mode_legal = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/slpc_sync.sv
module slpc_sync #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/slpc_policy.sv
module slpc_policy
  import slpc_pkg::*;
(
  input  logic [2:0]       mode,
  input  logic             async_tmr,
  input  logic             gie,
  input  logic             tmr2_ie,
  output logic [NWAKE-1:0] wake_mask,
  output dom_en_t          sleep_dom
);
  logic [NWAKE-1:0] base;

  always_comb begin
    base      = '0;
    sleep_dom = '0;
    case (mode)
      MODE_IDLE: begin
        base      = 6'b111111;
        sleep_dom = '{cpu: 1'b0, flash: 1'b0, io: 1'b1, adc: 1'b1, asy: async_tmr, osc: 1'b1};
      end
      MODE_ADCQ: begin
        base      = 6'b011111;
        sleep_dom = '{cpu: 1'b0, flash: 1'b0, io: 1'b0, adc: 1'b1, asy: async_tmr, osc: 1'b1};
      end
      MODE_PSAVE: begin
        base         = 6'b000011;
        base[WK_TM2] = async_tmr;
        sleep_dom    = '{cpu: 1'b0, flash: 1'b0, io: 1'b0, adc: 1'b0, asy: async_tmr, osc: 1'b0};
      end
      MODE_STBY: begin
        base      = 6'b000011;
        sleep_dom = '{cpu: 1'b0, flash: 1'b0, io: 1'b0, adc: 1'b0, asy: 1'b0, osc: 1'b1};
      end
      default: begin
        base      = 6'b000011;
        sleep_dom = '0;
      end
    endcase
    wake_mask         = base & {NWAKE{gie}};
    wake_mask[WK_TM2] = base[WK_TM2] & gie & tmr2_ie;
  end
endmodule

// File: rtl/slpc_seq.sv
module slpc_seq
  import slpc_pkg::*;
#(
  parameter int STARTUP_CYC = 32,
  parameter int STBY_CYC    = 6,
  parameter int HALT_CYC    = 4,
  parameter int CW          = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enter,
  input  logic       entry_adc,
  input  logic [2:0] mode_in,
  input  logic       wake,
  output slp_state_e st,
  output logic [2:0] mode_q,
  output logic       adc_start
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] slen;

  always_comb begin
    case (mode_q)
      MODE_PDOWN, MODE_PSAVE: slen = CW'(STARTUP_CYC);
      MODE_STBY:              slen = CW'(STBY_CYC);
      default:                slen = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_RUN;
      mode_q    <= MODE_IDLE;
      cnt       <= '0;
      adc_start <= 1'b0;
    end else begin
      adc_start <= 1'b0;
      case (st)
        ST_RUN: if (enter) begin
          st        <= ST_SLEEP;
          mode_q    <= mode_in;
          adc_start <= entry_adc;
        end
        ST_SLEEP: if (wake) begin
          if (slen == '0) begin
            st  <= ST_HALT;
            cnt <= CW'(HALT_CYC - 1);
          end else begin
            st  <= ST_START;
            cnt <= slen - 1'b1;
          end
        end
        ST_START: begin
          if (cnt == '0) begin
            st  <= ST_HALT;
            cnt <= CW'(HALT_CYC - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          if (cnt == '0) st <= ST_RUN;
          else           cnt <= cnt - 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/slpc_top.sv
module slpc_top
  import slpc_pkg::*;
#(
  parameter int STARTUP_CYC = 32,
  parameter int STBY_CYC    = 6,
  parameter int HALT_CYC    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_en,
  input  logic [2:0]       mode_sel,
  input  logic             sleep_strobe,
  input  logic             xtal_sel,
  input  logic             async_tmr,
  input  logic             adc_on,
  input  logic             gie,
  input  logic             tmr2_ie,
  input  logic [NWAKE-1:0] wake_req,
  output logic             clk_cpu_en,
  output logic             clk_flash_en,
  output logic             clk_io_en,
  output logic             clk_adc_en,
  output logic             clk_asy_en,
  output logic             osc_run_en,
  output logic             cpu_halt,
  output logic             adc_start
);
  localparam int MAX_A = (STARTUP_CYC > STBY_CYC) ? STARTUP_CYC : STBY_CYC;
  localparam int MAXC  = (MAX_A > HALT_CYC) ? MAX_A : HALT_CYC;
  localparam int CW    = $clog2(MAXC + 1);

  logic [NWAKE-1:0] wake_s;
  logic [NWAKE-1:0] wake_mask;
  dom_en_t          sleep_dom;
  dom_en_t          dom;
  slp_state_e       st;
  logic [2:0]       mode_q;
  logic             enter;
  logic             entry_adc;
  logic             wake;

  slpc_sync #(.W(NWAKE)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(wake_req), .q(wake_s)
  );

  slpc_policy u_policy (
    .mode(mode_q), .async_tmr(async_tmr), .gie(gie), .tmr2_ie(tmr2_ie),
    .wake_mask(wake_mask), .sleep_dom(sleep_dom)
  );

  assign enter     = sleep_strobe && sleep_en && mode_legal(mode_sel, xtal_sel);
  assign entry_adc = adc_on && (mode_sel == MODE_IDLE || mode_sel == MODE_ADCQ);
  assign wake      = (st == ST_SLEEP) && |(wake_s & wake_mask);

  slpc_seq #(
    .STARTUP_CYC(STARTUP_CYC), .STBY_CYC(STBY_CYC), .HALT_CYC(HALT_CYC), .CW(CW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .enter(enter), .entry_adc(entry_adc),
    .mode_in(mode_sel), .wake(wake), .st(st), .mode_q(mode_q), .adc_start(adc_start)
  );

  always_comb begin
    dom = '{cpu: 1'b1, flash: 1'b1, io: 1'b1, adc: 1'b1, asy: async_tmr, osc: 1'b1};
    if (st == ST_SLEEP) begin
      dom = sleep_dom;
    end else if (st == ST_START) begin
      dom     = sleep_dom;
      dom.osc = 1'b1;
    end
  end

  assign clk_cpu_en   = dom.cpu;
  assign clk_flash_en = dom.flash;
  assign clk_io_en    = dom.io;
  assign clk_adc_en   = dom.adc;
  assign clk_asy_en   = dom.asy;
  assign osc_run_en   = dom.osc;
  assign cpu_halt     = (st != ST_RUN);
endmodule

// File: rtl/slpc_checker.sv
module slpc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       sleep_en,
  input logic       sleep_strobe,
  input logic [2:0] mode_sel,
  input logic       clk_cpu_en,
  input logic       clk_flash_en,
  input logic       clk_io_en,
  input logic       clk_adc_en,
  input logic       osc_run_en,
  input logic       cpu_halt,
  input logic       adc_start
);
  p_entry_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_halt) |-> $past(sleep_strobe && sleep_en));

  p_reserved_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_halt && sleep_strobe && (mode_sel == 3'b100 || mode_sel == 3'b101 || mode_sel == 3'b111))
    |=> !cpu_halt);

  p_cpu_gated_only_halted_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_cpu_en || !clk_flash_en) |-> cpu_halt);

  p_osc_off_all_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_run_en |-> (!clk_cpu_en && !clk_flash_en && !clk_io_en && !clk_adc_en));

  p_adc_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);

  p_adc_on_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> $rose(cpu_halt));

  p_halt_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_halt) |-> ($past(cpu_halt, 4) && $past(clk_cpu_en)));
endmodule

bind slpc_top slpc_checker u_chk (.*);

// File: tb/slpc_top_bench.sv
module slpc_top_bench;
  localparam int SU = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sleep_en = 1'b0, sleep_strobe = 1'b0, xtal_sel = 1'b0;
  logic       async_tmr = 1'b0, adc_on = 1'b1, gie = 1'b1, tmr2_ie = 1'b1;
  logic [2:0] mode_sel = 3'b000;
  logic [5:0] wake_req = '0;
  logic clk_cpu_en, clk_flash_en, clk_io_en, clk_adc_en, clk_asy_en, osc_run_en;
  logic cpu_halt, adc_start;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  slpc_top #(.STARTUP_CYC(SU)) u_slpc_top (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int doms();
    return {clk_cpu_en, clk_flash_en, clk_io_en, clk_adc_en, clk_asy_en, osc_run_en};
  endfunction

  function automatic int run_dom(input bit a);
    return {4'b1111, a, 1'b1};
  endfunction

  function automatic int exp_dom(input int m, input bit a);
    case (m)
      0: return {4'b0011, a, 1'b1};
      1: return {4'b0001, a, 1'b1};
      3: return {4'b0000, a, 1'b0};
      6: return 6'b000001;
      default: return 0;
    endcase
  endfunction

  function automatic bit legal(input int m, input bit x);
    return (m <= 3) || (m == 6 && x);
  endfunction

  function automatic bit exp_wake(input int m, input int b, input bit a);
    if (b <= 1) return 1'b1;
    if (m == 0) return 1'b1;
    if (m == 1) return b <= 4;
    if (m == 3) return b == 2 && a;
    return 1'b0;
  endfunction

  function automatic int exp_lat(input int m);
    if (m <= 1) return 7;
    if (m == 6) return 6 + 7;
    return SU + 7;
  endfunction

  task automatic reset_dut();
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic enter(input int m, input bit x, input bit en);
    @(negedge clk);
    mode_sel = 3'(m); xtal_sel = x; sleep_en = en; sleep_strobe = 1'b1;
    @(negedge clk) sleep_strobe = 1'b0;
  endtask

  task automatic wait_wake(output int n);
    n = 0;
    while (n < 40) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (!cpu_halt) break;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    int modes[5] = '{0, 1, 2, 3, 6};
    reset_dut();
    @(negedge clk);
    chk(cpu_halt == 1'b0, "R11 reset halt", cpu_halt, 0);
    chk(doms() == run_dom(0), "R11 reset enables", doms(), run_dom(0));

    // R1: no strobe, then strobe with enable low
    sleep_en = 1'b1; repeat (5) @(negedge clk);
    chk(cpu_halt == 1'b0, "R1 no strobe", cpu_halt, 0);
    enter(0, 1, 0);
    chk(cpu_halt == 1'b0, "R1 enable low", cpu_halt, 0);

    // R2/R3/R4/R5/R8 entry sweep over all codes, crystal and async settings
    for (int m = 0; m < 8; m++)
      for (int x = 0; x < 2; x++)
        for (int a = 0; a < 2; a++) begin
          async_tmr = a[0];
          reset_dut();
          enter(m, x[0], 1);
          chk(cpu_halt == legal(m, x[0]), (m == 6) ? "R5 standby legality" : "R2 entry legality",
              cpu_halt, legal(m, x[0]));
          if (legal(m, x[0])) begin
            chk(doms() == exp_dom(m, a[0]), (m <= 1) ? "R3 gating" : (m == 6) ? "R5 gating" : "R4 gating",
                doms(), exp_dom(m, a[0]));
            chk(adc_start == (m <= 1), "R8 adc start pulse", adc_start, m <= 1);
            @(negedge clk);
            chk(adc_start == 1'b0, "R8 adc start width", adc_start, 0);
          end else begin
            chk(doms() == run_dom(a[0]), "R11 running enables", doms(), run_dom(a[0]));
          end
        end

    // R8: ADC disabled
    async_tmr = 1'b0; adc_on = 1'b0;
    reset_dut(); enter(1, 1, 1);
    chk(adc_start == 1'b0, "R8 adc off", adc_start, 0);
    adc_on = 1'b1;

    // R6/R9 wake sweep
    foreach (modes[i])
      for (int a = 0; a < 2; a++)
        for (int b = 0; b < 6; b++) begin
          async_tmr = a[0];
          reset_dut();
          enter(modes[i], 1, 1);
          @(negedge clk) wake_req = 6'(1 << b);
          wait_wake(n);
          if (exp_wake(modes[i], b, a[0])) begin
            chk(n == exp_lat(modes[i]), "R9 wake latency", n, exp_lat(modes[i]));
            chk(doms() == run_dom(a[0]), "R9 clocks after wake", doms(), run_dom(a[0]));
          end else begin
            chk(cpu_halt == 1'b1, "R6 source ignored", cpu_halt, 1);
          end
          wake_req = '0;
        end

    // R9: start-up window keeps oscillator on and domains gated
    async_tmr = 1'b0;
    reset_dut(); enter(2, 1, 1);
    @(negedge clk) wake_req = 6'b000001;
    repeat (4) @(negedge clk);
    chk(osc_run_en == 1'b1, "R9 osc during start-up", osc_run_en, 1);
    chk(clk_io_en == 1'b0 && cpu_halt, "R9 gated during start-up", clk_io_en, 0);
    wake_req = '0;

    // R7: global enable and timer-2 enable
    gie = 1'b0;
    reset_dut(); enter(0, 1, 1);
    @(negedge clk) wake_req = 6'b000001;
    wait_wake(n);
    chk(cpu_halt == 1'b1, "R7 gie low blocks wake", cpu_halt, 1);
    wake_req = '0; gie = 1'b1; tmr2_ie = 1'b0; async_tmr = 1'b1;
    reset_dut(); enter(3, 1, 1);
    @(negedge clk) wake_req = 6'b000100;
    wait_wake(n);
    chk(cpu_halt == 1'b1, "R7 tmr2 enable low blocks wake", cpu_halt, 1);
    wake_req = '0; tmr2_ie = 1'b1;

    // R10: reset during sleep
    reset_dut(); enter(2, 1, 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b0; #1;
    chk(cpu_halt == 1'b0, "R10 reset wakes", cpu_halt, 0);
    chk(doms() == run_dom(1), "R10 enables on reset", doms(), run_dom(1));
    @(negedge clk) rst_n = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule